// File: doc/BRIEF.md
# Indirect Jump Target Ranking Table

This block keeps, for hard-to-predict indirect jumps, a small tagless table of frequency counters. The table ranks up to three candidate targets per jump. The target addresses themselves sit in separate target-buffer ways outside this block. The table only names which of those ways (slots 0, 1, 2) the front end should fetch from. Each entry is selected by folding the jump address together with the target that jump took last time. One static jump can therefore own several entries, one per recent history.

A lookup returns, one cycle later, the slot with the highest count and the slot with the second highest count. The front end predicates down these two paths and never a third. When one slot holds the maximum count and the other two are empty, an override flag tells the front end to skip predication and fetch only the leading slot. Once a jump resolves, an update names the slot that was actually taken. That slot's counter rises and the other two fall, all saturating.

Top module: `tst_target_select`

## Requirements
- R1: While reset is asserted and after it is released, every counter of every entry is 0. `sel_valid` and `sel_override` are 0, and `sel_first` and `sel_second` are 0.
- R2: The entry index is the XOR of all 10-bit chunks of the jump address and all 10-bit chunks of the last target. Chunk k covers bits [10k+9:10k], and the top chunk is zero-padded. Accesses whose address pairs fold to the same index share one entry.
- R3: `sel_valid` is 1 in exactly the cycle after `lk_valid` was 1. In a cycle after `lk_valid` was 0, `sel_valid` is 0 and `sel_first`, `sel_second` and `sel_override` keep their previous values.
- R4: `sel_first` is the slot (0, 1 or 2) with the highest counter in the looked-up entry. A tie goes to the lower slot number.
- R5: `sel_second` is the slot with the highest counter among the two slots other than `sel_first`, with a tie going to the lower slot number. It always differs from `sel_first` and is never 3.
- R6: `sel_override` is 1 exactly when the counter of `sel_first` is 3 and both other counters are 0. When it is 1, `sel_second` is the lowest slot number other than `sel_first`.
- R7: An update with slot s in 0..2 increments counter s, stopping at 3, and decrements the two other counters, stopping at 0.
- R8: An update with `upd_valid` 0, or with slot code 3, changes no counter.
- R9: A lookup and an update in the same cycle, including to the same entry, return the counters as they were before that update. The update takes effect for lookups in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Address of the jump being looked up |
| lk_last | input | PC_W | Last target seen for that jump |
| upd_valid | input | 1 | Update request |
| upd_pc | input | PC_W | Address of the resolved jump |
| upd_last | input | PC_W | Last target used to index the resolved jump |
| upd_slot | input | 2 | Slot actually taken; code 3 means none |
| sel_valid | output | 1 | Ranking result valid (one cycle after lookup) |
| sel_first | output | 2 | Most frequent slot |
| sel_second | output | 2 | Second most frequent slot |
| sel_override | output | 1 | Single dominant slot; skip predication |

## Verification
A lookup and an update can land in the same cycle, on the same entry or on entries that alias through the fold. The bench drives both requests together on one entry for a run of cycles with a varying taken slot. It also drives them through different address pairs that fold to one index. Each ranking is judged against a bench model of the counters as they stood before that cycle's update. The effect of the update is confirmed by the lookup in the following cycle.

// File: rtl/tst_pkg.sv
package tst_pkg;
  localparam int NUM_SLOTS = 3;
  localparam int SLOT_W    = 2;
  typedef logic [SLOT_W-1:0] slot_t;
  // Code one past the last real slot: marks "no slot".
  localparam slot_t SLOT_NONE = slot_t'(NUM_SLOTS);
endpackage

// File: rtl/tst_hash.sv
module tst_hash #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  tgt_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int FOLDS = (PC_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W = FOLDS * IDX_W;

  logic [PAD_W-1:0] pc_pad;
  logic [PAD_W-1:0] tgt_pad;

  assign pc_pad  = PAD_W'(pc_i);
  assign tgt_pad = PAD_W'(tgt_i);

  // XOR-fold every chunk of both operands into one index.
  always_comb begin
    idx_o = '0;
    for (int f = 0; f < FOLDS; f++) begin
      idx_o = idx_o ^ pc_pad[f*IDX_W +: IDX_W] ^ tgt_pad[f*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/tst_rank.sv
module tst_rank import tst_pkg::*; #(
  parameter int CNT_W = 2
) (
  input  logic [NUM_SLOTS*CNT_W-1:0] entry_i,
  output slot_t                      first_o,
  output slot_t                      second_o,
  output logic                       dominant_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_unpack
    assign cnt[i] = entry_i[i*CNT_W +: CNT_W];
  end

  int   fi;
  int   si;
  logic have_second;

  always_comb begin
    // Leader: strict compare keeps the lower slot on ties.
    fi = 0;
    for (int i = 1; i < NUM_SLOTS; i++) begin
      if (cnt[i] > cnt[fi]) fi = i;
    end
    // Runner-up among the remaining slots, same tie rule.
    si          = 0;
    have_second = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (i != fi && (!have_second || cnt[i] > cnt[si])) begin
        si          = i;
        have_second = 1'b1;
      end
    end
    // Dominance: leader saturated, all others empty.
    dominant_o = (cnt[fi] == CMAX);
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (i != fi && cnt[i] != '0) dominant_o = 1'b0;
    end
    first_o  = slot_t'(fi);
    second_o = slot_t'(si);
  end
endmodule

// File: rtl/tst_cnt_update.sv
module tst_cnt_update import tst_pkg::*; #(
  parameter int CNT_W = 2
) (
  input  logic [NUM_SLOTS*CNT_W-1:0] entry_i,
  input  slot_t                      slot_i,
  output logic [NUM_SLOTS*CNT_W-1:0] entry_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] dec;
    assign cur = entry_i[i*CNT_W +: CNT_W];
    assign inc = (cur == CMAX) ? cur : cur + 1'b1;
    assign dec = (cur == '0)   ? cur : cur - 1'b1;
    assign entry_o[i*CNT_W +: CNT_W] = (slot_i == slot_t'(i)) ? inc : dec;
  end
endmodule

// File: rtl/tst_target_select.sv
module tst_target_select import tst_pkg::*; #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10,
  parameter int CNT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [PC_W-1:0]   lk_last,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [PC_W-1:0]   upd_last,
  input  logic [SLOT_W-1:0] upd_slot,
  output logic              sel_valid,
  output logic [SLOT_W-1:0] sel_first,
  output logic [SLOT_W-1:0] sel_second,
  output logic              sel_override
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = NUM_SLOTS * CNT_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Index formation for both ports.
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] upd_idx;

  tst_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_hash (
    .pc_i (lk_pc),
    .tgt_i(lk_last),
    .idx_o(lk_idx)
  );

  tst_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_upd_hash (
    .pc_i (upd_pc),
    .tgt_i(upd_last),
    .idx_o(upd_idx)
  );

  // Counter storage.
  logic [ENT_W-1:0] tbl_q [DEPTH];
  logic [ENT_W-1:0] lk_entry;
  logic [ENT_W-1:0] upd_entry;
  logic [ENT_W-1:0] upd_next;
  logic             wr_en;

  assign lk_entry  = tbl_q[lk_idx];
  assign upd_entry = tbl_q[upd_idx];

  tst_cnt_update #(.CNT_W(CNT_W)) u_upd (
    .entry_i(upd_entry),
    .slot_i (upd_slot),
    .entry_o(upd_next)
  );

  assign wr_en = upd_valid && (upd_slot < SLOT_NONE);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
    end else if (wr_en) begin
      tbl_q[upd_idx] <= upd_next;
    end
  end

  // Ranking of the looked-up entry (pre-update values).
  slot_t rk_first;
  slot_t rk_second;
  logic  rk_dom;

  tst_rank #(.CNT_W(CNT_W)) u_rank (
    .entry_i   (lk_entry),
    .first_o   (rk_first),
    .second_o  (rk_second),
    .dominant_o(rk_dom)
  );

  // Output register: next-state and state processes.
  slot_t first_d, second_d;
  logic  ovr_d;

  always_comb begin
    first_d  = sel_first;
    second_d = sel_second;
    ovr_d    = sel_override;
    if (lk_valid) begin
      first_d  = rk_first;
      second_d = rk_second;
      ovr_d    = rk_dom;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_valid    <= 1'b0;
      sel_first    <= '0;
      sel_second   <= '0;
      sel_override <= 1'b0;
    end else begin
      sel_valid    <= lk_valid;
      sel_first    <= first_d;
      sel_second   <= second_d;
      sel_override <= ovr_d;
    end
  end
endmodule

// File: rtl/tst_target_select_chk.sv
module tst_target_select_chk import tst_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              sel_valid,
  input logic [SLOT_W-1:0] sel_first,
  input logic [SLOT_W-1:0] sel_second,
  input logic              sel_override
);
  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!sel_valid && !sel_override); // R1
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> sel_valid); // R3

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !sel_valid); // R3

  AST_TWO_DISTINCT_PATHS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_first != sel_second) && (sel_first != SLOT_NONE)
                  && (sel_second != SLOT_NONE)); // R5

  AST_OVERRIDE_RUNNER_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_override) |->
      (sel_second == ((sel_first == 2'd0) ? 2'd1 : 2'd0))); // R6
endmodule

bind tst_target_select tst_target_select_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .lk_valid    (lk_valid),
  .sel_valid   (sel_valid),
  .sel_first   (sel_first),
  .sel_second  (sel_second),
  .sel_override(sel_override)
);

// File: tb/tst_target_select_bench.sv
`timescale 1ns/1ps
module tst_target_select_bench;
  logic        clk;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_pc;
  logic [31:0] lk_last;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic [31:0] upd_last;
  logic [1:0]  upd_slot;
  logic        sel_valid;
  logic [1:0]  sel_first;
  logic [1:0]  sel_second;
  logic        sel_override;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int mdl [1024][3];
  int prev_first = 0, prev_second = 0, prev_ovr = 0;

  tst_target_select u_tst_target_select (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_last(lk_last),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_last(upd_last), .upd_slot(upd_slot),
    .sel_valid(sel_valid), .sel_first(sel_first), .sel_second(sel_second),
    .sel_override(sel_override)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hidx(input logic [31:0] pc, input logic [31:0] lt);
    int r = 0;
    for (int k = 0; k < 4; k++) r = r ^ int'((pc >> (10*k)) & 32'h3ff) ^ int'((lt >> (10*k)) & 32'h3ff);
    return r;
  endfunction

  // Score = count*4 + (3 - slot): larger count wins, lower slot wins ties.
  task automatic rank_model(input int e, output int f, output int s, output int o);
    int best = -1;
    f = 0; s = 0;
    for (int i = 0; i < 3; i++) if (mdl[e][i]*4 + 3 - i > best) begin best = mdl[e][i]*4 + 3 - i; f = i; end
    best = -1;
    for (int i = 0; i < 3; i++) if (i != f && mdl[e][i]*4 + 3 - i > best) begin best = mdl[e][i]*4 + 3 - i; s = i; end
    o = (mdl[e][f] == 3 && mdl[e][0] + mdl[e][1] + mdl[e][2] == 3) ? 1 : 0;
  endtask

  task automatic step(input bit lv, input logic [31:0] lpc, input logic [31:0] llt,
                      input bit uv, input logic [31:0] upc, input logic [31:0] ult,
                      input logic [1:0] us, input string tag);
    int ef, es, eo, ui;
    lk_valid = lv; lk_pc = lpc; lk_last = llt;
    upd_valid = uv; upd_pc = upc; upd_last = ult; upd_slot = us;
    rank_model(hidx(lpc, llt), ef, es, eo);
    @(posedge clk); #1;
    if (lv) begin
      chk(sel_valid == 1'b1, {tag, " R3 valid"}, int'(sel_valid), 1);
      chk(int'(sel_first) == ef, {tag, " R4 first"}, int'(sel_first), ef);
      chk(int'(sel_second) == es, {tag, " R5 second"}, int'(sel_second), es);
      chk(int'(sel_override) == eo, {tag, " R6 override"}, int'(sel_override), eo);
      prev_first = ef; prev_second = es; prev_ovr = eo;
    end else begin
      chk(sel_valid == 1'b0, {tag, " R3 idle valid"}, int'(sel_valid), 0);
      chk(int'(sel_first) == prev_first && int'(sel_second) == prev_second
          && int'(sel_override) == prev_ovr, {tag, " R3 hold"}, int'(sel_first), prev_first);
    end
    if (uv && us != 2'd3) begin
      ui = hidx(upc, ult);
      for (int i = 0; i < 3; i++) begin
        if (i == int'(us)) mdl[ui][i] = (mdl[ui][i] == 3) ? 3 : mdl[ui][i] + 1;
        else               mdl[ui][i] = (mdl[ui][i] == 0) ? 0 : mdl[ui][i] - 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    for (int e = 0; e < 1024; e++) for (int i = 0; i < 3; i++) mdl[e][i] = 0;
    rst_n = 0; lk_valid = 0; lk_pc = 0; lk_last = 0;
    upd_valid = 0; upd_pc = 0; upd_last = 0; upd_slot = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(sel_valid == 0 && sel_override == 0 && sel_first == 0 && sel_second == 0,
        "R1 reset outputs", int'(sel_valid), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(sel_valid == 0, "R1 after release", int'(sel_valid), 0);

    // R1/R4/R5: empty entry ranks 0 then 1
    step(1, 32'd900, 32'd0, 0, 0, 0, 0, "R1 empty entry");
    step(0, 0, 0, 0, 0, 0, 0, "R3 idle");

    // R7/R4/R5/R6: every 5-long sequence of taken slots on a fresh entry
    for (int seq = 0; seq < 243; seq++) begin
      int v = seq;
      step(1, 32'(seq), 32'd0, 0, 0, 0, 0, "R1 fresh sweep entry");
      for (int k = 0; k < 5; k++) begin
        step(0, 0, 0, 1, 32'(seq), 32'd0, 2'(v % 3), "R7 sweep update");
        step(1, 32'(seq), 32'd0, 0, 0, 0, 0, "R7 sweep lookup");
        v = v / 3;
      end
    end

    // R9: lookup and update together on one entry
    for (int c = 0; c < 24; c++)
      step(1, 32'd600, 32'd0, 1, 32'd600, 32'd0, 2'((c / 4 + c) % 3), "R9 same cycle");
    step(1, 32'd600, 32'd0, 0, 0, 0, 0, "R9 after");

    // R2: aliases folding to index 700 share one entry
    for (int c = 0; c < 3; c++)
      step(1, 32'd0, 32'd700 << 20, 1, 32'd700 << 10, 32'd0, 2'd2, "R2 R9 alias");
    step(1, 32'd700, 32'd0, 0, 0, 0, 0, "R2 alias read");
    step(1, 32'd700, 32'd5, 0, 0, 0, 0, "R2 other history");
    step(1, 32'hC000_0000, 32'd0, 0, 0, 0, 0, "R2 top chunk");
    step(1, 32'd3, 32'hC000_0003, 0, 0, 0, 0, "R2 both operands");

    // R8: ignored updates leave entry 700 unchanged
    for (int c = 0; c < 4; c++) step(0, 0, 0, 0, 32'd700, 32'd0, 2'd0, "R8 valid low");
    step(1, 32'd700, 32'd0, 0, 0, 0, 0, "R8 check valid low");
    for (int c = 0; c < 4; c++) step(0, 0, 0, 1, 32'd700, 32'd0, 2'd3, "R8 slot three");
    step(1, 32'd700, 32'd0, 0, 0, 0, 0, "R8 check slot three");
    chk(sel_override == 1'b1 && sel_first == 2'd2, "R8 R6 still dominant", int'(sel_first), 2);

    finish_run();
  end
endmodule